// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between an on-chip master and an external 128K x 8 asynchronous static RAM. The RAM has one bidirectional byte bus, an active-low and an active-high chip enable, an active-low output enable and an active-low write enable. The master raises a request together with a 17-bit address, a write flag and a write byte. The controller accepts it when idle, runs the RAM pin sequence for that access, and answers with a one-cycle acknowledge. For a read, the fetched byte is on the read-data port during that acknowledge.

All waits are counted in clock cycles. Each wait is derived from a time in picoseconds and the clock period as ceil(time / period), with a floor of one cycle. The write pulse lasts long enough to satisfy both the minimum pulse width and the data-valid-before-end-of-write time. The read access lasts long enough to satisfy both the address access time and the output-enable access time.

The bidirectional bus is split into an output byte, an output-enable and an input byte, so that the pad cell sits outside the block. The controller drives the bus only for a write. It holds the RAM output enable high during a write, so the RAM and the controller never drive the bus together.

The state machine has six states:
- ST_IDLE: bus released, RAM deselected. A request moves it to ST_WR_SETUP (write) or ST_RD_ACCESS (read).
- ST_WR_SETUP: one cycle. It leads to ST_WR_PULSE.
- ST_WR_PULSE: lasts the write-cycle count. It leads to ST_WR_HOLD.
- ST_WR_HOLD: one cycle. It leads to ST_DONE.
- ST_RD_ACCESS: lasts the read-cycle count. It leads to ST_DONE and captures the read byte on the exit edge.
- ST_DONE: one cycle. It leads back to ST_IDLE.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is applied, and in the cycle after it ends: ram_ce_n=1, ram_ce=0, ram_oe_n=1, ram_we_n=1, ram_dq_oe=0, host_ack=0, host_busy=0.
- R2: A request is accepted only in idle. A request held while host_busy=1 and dropped before the controller returns to idle causes no RAM write, and the address it names keeps its old contents.
- R3: A write runs through four phases:
  - Setup: one cycle with the RAM selected (ram_ce_n=0, ram_ce=1), ram_we_n=1, ram_dq_oe=1 and the write byte on ram_dq_out.
  - Pulse: ram_we_n=0 for the write-cycle count, with ram_addr and ram_dq_out stable.
  - Hold: one cycle after ram_we_n rises, with ram_dq_oe still 1 and the RAM deselected.
  - Release: ram_dq_oe=0 from the acknowledge cycle onward.
- R4: ram_oe_n stays 1 for the whole of a write. ram_oe_n=0 and ram_dq_oe=1 never occur in the same cycle.
- R5: A read holds the RAM selected with ram_oe_n=0 and ram_we_n=1 for the read-cycle count. It captures ram_dq_in on the last edge of that window. host_rdata then keeps that byte until the next read, and writes do not change it.
- R6: host_ack is high for exactly one cycle. For a write it arrives 3 + write-cycle count cycles after the accepting edge; for a read it arrives 1 + read-cycle count cycles after. host_busy is 1 from the cycle after acceptance through the acknowledge cycle, and 0 in the cycle after.
- R7: ram_we_n is 0 only while the RAM is selected (ram_ce_n=0 and ram_ce=1). Its falling edge is preceded by a cycle in which the RAM was already selected.
- R8: The write-cycle count is max(ceil(T_WP_PS/CLK_PS), ceil(T_DW_PS/CLK_PS), 1). The read-cycle count is max(ceil(T_AA_PS/CLK_PS), ceil(T_OE_PS/CLK_PS), 1). With the defaults (8000, 12000, 7000, 15000, 6000) both counts are 2.
- R9: ram_addr holds the accepted address from the cycle after acceptance through the acknowledge cycle, at the lowest and highest addresses as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, sampled in idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Last byte read |
| host_ack | output | 1 | One-cycle completion pulse |
| host_busy | output | 1 | Transaction in progress |
| ram_addr | output | 17 | RAM address pins |
| ram_ce_n | output | 1 | Active-low chip enable |
| ram_ce | output | 1 | Active-high chip enable |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write enable |
| ram_dq_out | output | 8 | Byte driven onto the RAM bus |
| ram_dq_oe | output | 1 | 1 = controller drives the RAM bus |
| ram_dq_in | input | 8 | Byte sampled from the RAM bus |

## Verification
The case that is hardest to reach from the ports is a request that arrives while a write is still running: it must be dropped, not queued. The bench holds a second write request with a different address and byte through the busy cycles. It releases that request one cycle before the controller would return to idle. It then checks two things: the bus monitor saw exactly one write pulse, and a read of the second address returns the model's untouched default. The bench's RAM model returns valid data only from the second cycle of an enabled read, so a controller that captures too early reads a filler byte.

// File: rtl/sram_async_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_async_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_DONE
    } ctrl_state_t;

    typedef struct packed {
        logic ce_n;
        logic ce;
        logic oe_n;
        logic we_n;
        logic dq_oe;
        logic ack;
        logic busy;
    } pin_set_t;

    localparam pin_set_t PINS_QUIET = '{ce_n: 1'b1, ce: 1'b0, oe_n: 1'b1,
                                        we_n: 1'b1, dq_oe: 1'b0, ack: 1'b0,
                                        busy: 1'b0};

    function automatic int unsigned wait_cycles(input int unsigned need_ps,
                                                input int unsigned clk_ps);
        int unsigned c;
        c = (need_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_async_ctrl_timer.sv
`timescale 1ns/1ps
module sram_async_ctrl_timer #(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign last = (remain_q == CW'(1));

    // R8
    timer_load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/sram_async_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_async_ctrl_fsm import sram_async_ctrl_pkg::*; #(
    parameter int unsigned CW     = 2,
    parameter int unsigned WR_CYC = 2,
    parameter int unsigned RD_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr,
    input  logic          t_last,
    output logic          t_load,
    output logic [CW-1:0] t_val,
    output logic          accept,
    output logic          capture,
    output pin_set_t      pins
);
    ctrl_state_t state_q, state_nxt;

    always_comb begin
        state_nxt = state_q;
        t_load    = 1'b0;
        t_val     = CW'(1);
        accept    = 1'b0;
        capture   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    if (wr) begin
                        state_nxt = ST_WR_SETUP;
                    end else begin
                        state_nxt = ST_RD_ACCESS;
                        t_load    = 1'b1;
                        t_val     = CW'(RD_CYC);
                    end
                end
            end
            ST_WR_SETUP: begin
                state_nxt = ST_WR_PULSE;
                t_load    = 1'b1;
                t_val     = CW'(WR_CYC);
            end
            ST_WR_PULSE: begin
                if (t_last) state_nxt = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_nxt = ST_DONE;
            end
            ST_RD_ACCESS: begin
                if (t_last) begin
                    state_nxt = ST_DONE;
                    capture   = 1'b1;
                end
            end
            ST_DONE: begin
                state_nxt = ST_IDLE;
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Registered outputs, decoded from the next state so pins never glitch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins <= PINS_QUIET;
        end else begin
            pins <= PINS_QUIET;
            unique case (state_nxt)
                ST_IDLE: ;
                ST_WR_SETUP: begin
                    pins.ce_n  <= 1'b0;
                    pins.ce    <= 1'b1;
                    pins.dq_oe <= 1'b1;
                    pins.busy  <= 1'b1;
                end
                ST_WR_PULSE: begin
                    pins.ce_n  <= 1'b0;
                    pins.ce    <= 1'b1;
                    pins.we_n  <= 1'b0;
                    pins.dq_oe <= 1'b1;
                    pins.busy  <= 1'b1;
                end
                ST_WR_HOLD: begin
                    pins.dq_oe <= 1'b1;
                    pins.busy  <= 1'b1;
                end
                ST_RD_ACCESS: begin
                    pins.ce_n  <= 1'b0;
                    pins.ce    <= 1'b1;
                    pins.oe_n  <= 1'b0;
                    pins.busy  <= 1'b1;
                end
                ST_DONE: begin
                    pins.ack   <= 1'b1;
                    pins.busy  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R6
    ack_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pins.ack |=> !pins.ack);

    // R6
    idle_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pins.ack |=> !pins.busy);

endmodule

// File: rtl/sram_async_ctrl_datapath.sv
`timescale 1ns/1ps
module sram_async_ctrl_datapath #(
    parameter int unsigned AW = 17,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic [DW-1:0] bus_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= bus_in;
    end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl import sram_async_ctrl_pkg::*; #(
    parameter int unsigned AW       = 17,
    parameter int unsigned DW       = 8,
    parameter int unsigned CLK_PS   = 8000,
    parameter int unsigned T_WP_PS  = 12000,
    parameter int unsigned T_DW_PS  = 7000,
    parameter int unsigned T_AA_PS  = 15000,
    parameter int unsigned T_OE_PS  = 6000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_ack,
    output logic          host_busy,
    output logic [AW-1:0] ram_addr,
    output logic          ram_ce_n,
    output logic          ram_ce,
    output logic          ram_oe_n,
    output logic          ram_we_n,
    output logic [DW-1:0] ram_dq_out,
    output logic          ram_dq_oe,
    input  logic [DW-1:0] ram_dq_in
);
    localparam int unsigned WR_CYC = max2(wait_cycles(T_WP_PS, CLK_PS),
                                          wait_cycles(T_DW_PS, CLK_PS));
    localparam int unsigned RD_CYC = max2(wait_cycles(T_AA_PS, CLK_PS),
                                          wait_cycles(T_OE_PS, CLK_PS));
    localparam int unsigned CW     = $clog2(max2(WR_CYC, RD_CYC) + 1);

    logic          t_load, t_last, accept, capture;
    logic [CW-1:0] t_val;
    pin_set_t      pins;

    sram_async_ctrl_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    sram_async_ctrl_fsm #(.CW(CW), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC)) i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (host_req),
        .wr      (host_wr),
        .t_last  (t_last),
        .t_load  (t_load),
        .t_val   (t_val),
        .accept  (accept),
        .capture (capture),
        .pins    (pins)
    );

    sram_async_ctrl_datapath #(.AW(AW), .DW(DW)) i_datapath (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .capture  (capture),
        .in_addr  (host_addr),
        .in_wdata (host_wdata),
        .bus_in   (ram_dq_in),
        .addr_q   (ram_addr),
        .wdata_q  (ram_dq_out),
        .rdata_q  (host_rdata)
    );

    assign ram_ce_n  = pins.ce_n;
    assign ram_ce    = pins.ce;
    assign ram_oe_n  = pins.oe_n;
    assign ram_we_n  = pins.we_n;
    assign ram_dq_oe = pins.dq_oe;
    assign host_ack  = pins.ack;
    assign host_busy = pins.busy;

    // R7
    we_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_ce_n && ram_ce));

    // R7
    select_before_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_we_n) |-> $past(!ram_ce_n && ram_ce));

    // R4
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> (!ram_dq_oe && ram_we_n));

    // R3
    wr_addr_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |=> (ram_we_n || ($stable(ram_addr) && $stable(ram_dq_out))));

    // R3
    bus_held_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> ram_dq_oe);

    // R3
    bus_released_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (!ram_dq_oe && ram_ce_n && !ram_ce));

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

    localparam int AW = 17;
    localparam int DW = 8;

    function automatic int ceil_min1(input int need, input int per);
        int c;
        c = (need + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    // R8 expected counts, from the requirement formula and default times
    localparam int WP_EXP = (ceil_min1(12000, 8000) > ceil_min1(7000, 8000)) ?
                            ceil_min1(12000, 8000) : ceil_min1(7000, 8000);
    localparam int RD_EXP = (ceil_min1(15000, 8000) > ceil_min1(6000, 8000)) ?
                            ceil_min1(15000, 8000) : ceil_min1(6000, 8000);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_ack, host_busy;
    logic [AW-1:0] ram_addr;
    logic          ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_dq_oe;
    logic [DW-1:0] ram_dq_out;
    logic [DW-1:0] ram_dq_in = 8'hA5;

    int checks = 0;
    int errors = 0;
    int wr_pulses = 0;

    always #4 clk = ~clk;

    sram_async_ctrl i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ack(host_ack), .host_busy(host_busy),
        .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_ce(ram_ce),
        .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // RAM model: byte storage, data valid from the 2nd enabled read cycle
    logic [DW-1:0] mem [logic [AW-1:0]];
    int            rd_cnt = 0;
    int            low_run = 0;
    logic          prev_low = 1'b0;
    logic [AW-1:0] prev_addr;
    logic [DW-1:0] prev_data;

    function automatic logic [DW-1:0] mem_get(input logic [AW-1:0] a);
        return mem.exists(a) ? mem[a] : 8'hC3;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ram_ce_n && ram_ce && !ram_oe_n && ram_we_n) begin
                rd_cnt = rd_cnt + 1;
                ram_dq_in = (rd_cnt >= 2) ? mem_get(ram_addr) : 8'hA5;
            end else begin
                rd_cnt = 0;
                ram_dq_in = 8'hA5;
            end
            if (!ram_oe_n) check(!ram_dq_oe, "R4 bus fight", ram_dq_oe, 0);
            if (!ram_we_n) begin
                check(!ram_ce_n && ram_ce, "R7 we without select", {ram_ce_n, ram_ce}, 2'b01);
                check(ram_oe_n, "R4 oe during write", ram_oe_n, 1);
                check(ram_dq_oe, "R3 bus driven in pulse", ram_dq_oe, 1);
                if (prev_low) begin
                    check(ram_addr == prev_addr, "R3 addr stable", ram_addr, prev_addr);
                    check(ram_dq_out == prev_data, "R3 data stable", ram_dq_out, prev_data);
                end
                low_run++;
                prev_low  = 1'b1;
                prev_addr = ram_addr;
                prev_data = ram_dq_out;
            end else if (prev_low) begin
                check(low_run == WP_EXP, "R8 write pulse length", low_run, WP_EXP);
                check(ram_dq_oe, "R3 bus held after we rise", ram_dq_oe, 1);
                mem[prev_addr] = prev_data;
                wr_pulses++;
                low_run  = 0;
                prev_low = 1'b0;
            end
        end
    end

    // One host transaction; checks latency, ack width, busy, address hold
    task automatic do_op(input bit wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] rd);
        int lat;
        int exp_lat;
        exp_lat = wr ? (3 + WP_EXP) : (1 + RD_EXP);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        check(host_busy, "R6 busy after accept", host_busy, 1);
        while (!host_ack && lat < 40) begin
            check(ram_addr == a, "R9 address held", ram_addr, a);
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, "R6 ack latency", lat, exp_lat);
        check(host_busy, "R6 busy in ack cycle", host_busy, 1);
        check(!ram_dq_oe, "R3 bus released at ack", ram_dq_oe, 0);
        check(ram_addr == a, "R9 address at ack", ram_addr, a);
        rd = host_rdata;
        @(negedge clk);
        check(!host_ack, "R6 ack one cycle", host_ack, 0);
        check(!host_busy, "R6 busy drops", host_busy, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_dq_oe, host_ack, host_busy} == 7'b1011000,
              "R1 reset pins", {ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_dq_oe, host_ack, host_busy},
              7'b1011000);
        rst_n = 1'b1;
        @(negedge clk);
        check({ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_dq_oe, host_ack, host_busy} == 7'b1011000,
              "R1 idle after reset", {ram_ce_n, ram_ce, ram_oe_n, ram_we_n, ram_dq_oe, host_ack, host_busy},
              7'b1011000);
    endtask

    task automatic t_write_read;
        logic [DW-1:0] r;
        int w0;
        w0 = wr_pulses;
        do_op(1'b1, 17'h00ABC, 8'h3C, r);
        check(wr_pulses == w0 + 1, "R3 one pulse per write", wr_pulses, w0 + 1);
        do_op(1'b1, 17'h00ABD, 8'h96, r);
        do_op(1'b0, 17'h00ABC, 8'h00, r);
        check(r == 8'h3C, "R5 read data", r, 8'h3C);
        do_op(1'b0, 17'h00ABD, 8'h00, r);
        check(r == 8'h96, "R5 read data second", r, 8'h96);
        do_op(1'b1, 17'h00777, 8'h01, r);
        check(host_rdata == 8'h96, "R5 rdata held across write", host_rdata, 8'h96);
    endtask

    task automatic t_boundary;
        logic [DW-1:0] r;
        do_op(1'b1, 17'h00000, 8'h00, r);
        do_op(1'b1, 17'h1FFFF, 8'hFF, r);
        do_op(1'b0, 17'h1FFFF, 8'h00, r);
        check(r == 8'hFF, "R9 top address read", r, 8'hFF);
        do_op(1'b0, 17'h00000, 8'h00, r);
        check(r == 8'h00, "R9 bottom address read", r, 8'h00);
        do_op(1'b0, 17'h15555, 8'h00, r);
        check(r == 8'hC3, "R5 unwritten location", r, 8'hC3);
    endtask

    task automatic t_busy_ignore;
        logic [DW-1:0] r;
        int w0;
        w0 = wr_pulses;
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_addr = 17'h00100; host_wdata = 8'h11;
        @(negedge clk);
        host_addr = 17'h00200; host_wdata = 8'h22;
        repeat (2) @(negedge clk);
        check(host_busy, "R2 busy while held", host_busy, 1);
        @(negedge clk);
        host_req = 1'b0;
        while (!host_ack) @(negedge clk);
        repeat (3) @(negedge clk);
        check(wr_pulses == w0 + 1, "R2 extra request dropped", wr_pulses, w0 + 1);
        do_op(1'b0, 17'h00200, 8'h00, r);
        check(r == 8'hC3, "R2 ignored address untouched", r, 8'hC3);
        do_op(1'b0, 17'h00100, 8'h00, r);
        check(r == 8'h11, "R2 first request written", r, 8'h11);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_write_read();
        t_boundary();
        t_busy_ignore();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule